// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator

This block turns a 32-bit virtual address into a physical address through two on-chip lookup tables. The first table, the segment map, is selected by the current context number together with the virtual segment field of the address, and returns a page-group number. The second table, the page-entry RAM, is indexed by that group number and the virtual page field, and returns a 32-bit page entry. The entry carries a frame number, protection and caching attributes, a space type, and two status bits. There are no page tables in memory: both tables are filled by software through a separate register-style port.

Each translation is a fixed three-step pipeline: segment read, entry read, then check and update. The address is first screened for the hole in the middle of the address space. The entry is then checked for validity, write permission and supervisor-only access, in that order. On success the block returns the physical address, the non-cacheable flag and the space type. It also sets the referenced bit, plus the modified bit for writes, and writes the entry back in place. On a fault it returns a 2-bit fault code and leaves the entry alone.

A software access to either table takes priority and freezes the translation pipeline for that cycle. Both tables power up undefined and must be written before use. With the default parameters, the segment map keeps the low 8 bits of the 12-bit segment field (2048 entries), and the page RAM holds 32 groups of 64 entries.

Top module: `mmu_xlate`

## Requirements
- R1: When virtual address bits 31:29 are neither 000 nor 111, the response carries fault code 1 (hole), whatever the table contents, and no entry is modified.
- R2: The segment map is read at address {context, va[25:18]} (context in bits 10:8). The page RAM is read at address {group, va[17:12]} (group in bits 10:6). Segment-field bits 29:26 do not take part in the lookup.
- R3: An entry whose bit 31 (valid) is 0 gives fault code 2 (invalid). This takes precedence over every protection check.
- R4: A write to an entry whose bit 30 (write-allowed) is 0 gives fault code 3 (protection). So does a user-mode access to an entry whose bit 29 (supervisor-only) is 1.
- R5: On success the fault code is 0 and rsp_pa = {entry[15:0], va[11:0]}. rsp_nc equals entry bit 28 and rsp_space equals entry bits 27:26.
- R6: On success the entry is written back with bit 25 (referenced) set, and with bit 24 (modified) also set when the access is a write. All other bits are unchanged.
- R7: On any fault the entry is left unchanged, and rsp_pa, rsp_nc and rsp_space are all zero.
- R8: After reset req_ready is 1 and rsp_valid is 0. A request is accepted on an edge where req_valid and req_ready are both 1. rsp_valid is high for exactly one cycle, starting at the second rising edge after the accepting edge. req_ready stays 0 until then.
- R9: While sw_en is 1, req_ready is 0 and the translation pipeline holds its state, so each such cycle adds one cycle to the latency. A read (sw_wr = 0) returns the addressed word on sw_rdata with sw_rvalid = 1 one cycle later. sw_sel = 0 selects the segment map (the group number is zero-extended) and sw_sel = 1 selects the page RAM.
- R10: A user-mode page with protection bits 31:29 = 110 allows user reads and writes. With 100 it allows user reads and faults user writes with code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address |
| req_ctx | input | 3 | Current context number |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 28 | Physical address |
| rsp_nc | output | 1 | Access must bypass the cache |
| rsp_space | output | 2 | Space type of the page |
| rsp_fault | output | 2 | 0 none, 1 hole, 2 invalid, 3 protection |
| sw_en | input | 1 | Software table access this cycle |
| sw_wr | input | 1 | 1 write, 0 read |
| sw_sel | input | 1 | 0 segment map, 1 page RAM |
| sw_addr | input | 11 | Table address |
| sw_wdata | input | 32 | Write data |
| sw_rvalid | output | 1 | Read data valid |
| sw_rdata | output | 32 | Read data |

## Verification
The assertions take for granted that every table location a request reaches has been written by software first. They also assume that req_va, req_ctx, req_write and req_user are only sampled on the accepting edge. The writeback checks therefore hold only on defined entries. The bench loads every segment and page entry it will use through the software port before any translation. It raises req_valid only in cycles where it has seen req_ready high. It uses sw_en during a translation only for reads, so that the stalled lookup still finds the same entry.

// File: rtl/mmu_pkg.sv
package mmu_pkg;

    localparam int PTE_W        = 32;
    localparam int BIT_VALID    = 31;
    localparam int BIT_WRITE    = 30;
    localparam int BIT_SUPER    = 29;
    localparam int BIT_NOCACHE  = 28;
    localparam int SPACE_LSB    = 26;
    localparam int BIT_REF      = 25;
    localparam int BIT_MOD      = 24;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_HOLE    = 2'd1,
        FLT_INVALID = 2'd2,
        FLT_PROT    = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ENTRY = 2'd1,
        ST_CHECK = 2'd2
    } xl_state_e;

    typedef struct packed {
        fault_e             fault;
        logic               ok;
        logic [PTE_W-1:0]   pte_new;
    } check_res_t;

    function automatic logic in_hole(input logic [2:0] top);
        return !((top == 3'b000) || (top == 3'b111));
    endfunction

endpackage

// File: rtl/mmu_ram.sv
module mmu_ram #(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re_a,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic          re_b,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (re_a)
            rdata_a <= mem[raddr_a];
    end

    always_ff @(posedge clk) begin
        if (re_b)
            rdata_b <= mem[raddr_b];
    end

endmodule

// File: rtl/mmu_check.sv
module mmu_check
    import mmu_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic             hole,
    input  logic             wr,
    input  logic             user,
    output check_res_t       res
);
    always_comb begin
        res.pte_new = pte;
        res.pte_new[BIT_REF] = 1'b1;
        if (wr)
            res.pte_new[BIT_MOD] = 1'b1;

        if (hole)
            res.fault = FLT_HOLE;
        else if (!pte[BIT_VALID])
            res.fault = FLT_INVALID;
        else if (wr && !pte[BIT_WRITE])
            res.fault = FLT_PROT;
        else if (user && pte[BIT_SUPER])
            res.fault = FLT_PROT;
        else
            res.fault = FLT_NONE;

        res.ok = (res.fault == FLT_NONE);
    end

endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
#(
    parameter int VA_W   = 32,
    parameter int CTX_W  = 3,
    parameter int SEGX_W = 8,
    parameter int PG_W   = 6,
    parameter int OFF_W  = 12,
    parameter int GRP_W  = 5,
    parameter int PFN_W  = 16,
    localparam int SEG_AW  = CTX_W + SEGX_W,
    localparam int PTE_AW  = GRP_W + PG_W,
    localparam int SW_AW   = (SEG_AW > PTE_AW) ? SEG_AW : PTE_AW,
    localparam int PA_W    = PFN_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic [CTX_W-1:0]  req_ctx,
    input  logic              req_write,
    input  logic              req_user,
    output logic              rsp_valid,
    output logic [PA_W-1:0]   rsp_pa,
    output logic              rsp_nc,
    output logic [1:0]        rsp_space,
    output logic [1:0]        rsp_fault,
    input  logic              sw_en,
    input  logic              sw_wr,
    input  logic              sw_sel,
    input  logic [SW_AW-1:0]  sw_addr,
    input  logic [PTE_W-1:0]  sw_wdata,
    output logic              sw_rvalid,
    output logic [PTE_W-1:0]  sw_rdata
);
    localparam int SEG_LSB = OFF_W + PG_W;
    localparam int LOW_W   = OFF_W + PG_W;

    xl_state_e         state;
    logic [LOW_W-1:0]  va_low_q;
    logic              wr_q, user_q, hole_q;
    logic              sel_q;

    logic              accept, advance, wb_en;
    logic [GRP_W-1:0]  grp_q, seg_sw_rd;
    logic [PTE_W-1:0]  pte_q, pte_sw_rd;
    check_res_t        chk;

    logic              seg_we, pte_we, pte_sw_we;
    logic [PTE_AW-1:0] pte_waddr, pte_raddr;
    logic [PTE_W-1:0]  pte_wdata;
    logic [SEG_AW-1:0] seg_raddr;

    logic unused_bits;
    assign unused_bits = ^{req_va[VA_W-4:SEG_LSB+SEGX_W], sw_wdata[PTE_W-1:GRP_W], sw_addr};

    assign advance   = !sw_en;
    assign req_ready = (state == ST_IDLE) && !sw_en;
    assign accept    = req_valid && req_ready;

    // segment map: context plus low segment-field bits
    assign seg_raddr = {req_ctx, req_va[SEG_LSB +: SEGX_W]};
    assign seg_we    = sw_en && sw_wr && !sw_sel;

    mmu_ram #(.DW(GRP_W), .AW(SEG_AW)) u_segmap (
        .clk     (clk),
        .we      (seg_we),
        .waddr   (sw_addr[SEG_AW-1:0]),
        .wdata   (sw_wdata[GRP_W-1:0]),
        .re_a    (accept),
        .raddr_a (seg_raddr),
        .rdata_a (grp_q),
        .re_b    (sw_en && !sw_wr && !sw_sel),
        .raddr_b (sw_addr[SEG_AW-1:0]),
        .rdata_b (seg_sw_rd)
    );

    // page-entry RAM: group plus page field; software write or status writeback
    assign pte_raddr = {grp_q, va_low_q[OFF_W +: PG_W]};
    assign pte_sw_we = sw_en && sw_wr && sw_sel;
    assign wb_en     = (state == ST_CHECK) && advance && chk.ok;
    assign pte_we    = pte_sw_we || wb_en;
    assign pte_waddr = pte_sw_we ? sw_addr[PTE_AW-1:0] : pte_raddr;
    assign pte_wdata = pte_sw_we ? sw_wdata : chk.pte_new;

    mmu_ram #(.DW(PTE_W), .AW(PTE_AW)) u_pteram (
        .clk     (clk),
        .we      (pte_we),
        .waddr   (pte_waddr),
        .wdata   (pte_wdata),
        .re_a    ((state == ST_ENTRY) && advance),
        .raddr_a (pte_raddr),
        .rdata_a (pte_q),
        .re_b    (sw_en && !sw_wr && sw_sel),
        .raddr_b (sw_addr[PTE_AW-1:0]),
        .rdata_b (pte_sw_rd)
    );

    mmu_check u_check (
        .pte  (pte_q),
        .hole (hole_q),
        .wr   (wr_q),
        .user (user_q),
        .res  (chk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b0;
            rsp_pa    <= '0;
            rsp_nc    <= 1'b0;
            rsp_space <= '0;
            rsp_fault <= FLT_NONE;
            va_low_q  <= '0;
            wr_q      <= 1'b0;
            user_q    <= 1'b0;
            hole_q    <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            if (advance) begin
                case (state)
                    ST_IDLE: if (accept) begin
                        va_low_q <= req_va[LOW_W-1:0];
                        wr_q     <= req_write;
                        user_q   <= req_user;
                        hole_q   <= in_hole(req_va[VA_W-1 -: 3]);
                        state    <= ST_ENTRY;
                    end
                    ST_ENTRY: state <= ST_CHECK;
                    ST_CHECK: begin
                        state     <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_fault <= chk.fault;
                        if (chk.ok) begin
                            rsp_pa    <= {pte_q[PFN_W-1:0], va_low_q[OFF_W-1:0]};
                            rsp_nc    <= pte_q[BIT_NOCACHE];
                            rsp_space <= pte_q[SPACE_LSB +: 2];
                        end else begin
                            rsp_pa    <= '0;
                            rsp_nc    <= 1'b0;
                            rsp_space <= '0;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_rvalid <= 1'b0;
            sel_q     <= 1'b0;
        end else begin
            sw_rvalid <= sw_en && !sw_wr;
            if (sw_en && !sw_wr)
                sel_q <= sw_sel;
        end
    end

    assign sw_rdata = sel_q ? pte_sw_rd : {{(PTE_W-GRP_W){1'b0}}, seg_sw_rd};

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R7
    fault_zero_out_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_pa == '0 && !rsp_nc && rsp_space == 2'b00));

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sw_en |=> (state == $past(state)));

    // R6
    wb_fields_chk: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (pte_wdata[BIT_REF] && pte_wdata[23:0] == pte_q[23:0]
                   && pte_wdata[31:26] == pte_q[31:26]));

    // R6
    wb_read_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_en && !wr_q) |-> (pte_wdata[BIT_MOD] == pte_q[BIT_MOD]));

endmodule

// File: tb/sim_mmu_xlate.sv
module sim_mmu_xlate;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_write, req_user;
    logic        req_ready;
    logic [31:0] req_va;
    logic [2:0]  req_ctx;
    logic        rsp_valid, rsp_nc;
    logic [27:0] rsp_pa;
    logic [1:0]  rsp_space, rsp_fault;
    logic        sw_en, sw_wr, sw_sel;
    logic [10:0] sw_addr;
    logic [31:0] sw_wdata, sw_rdata;
    logic        sw_rvalid;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    mmu_xlate u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
        .req_ctx(req_ctx), .req_write(req_write), .req_user(req_user),
        .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_nc(rsp_nc),
        .rsp_space(rsp_space), .rsp_fault(rsp_fault),
        .sw_en(sw_en), .sw_wr(sw_wr), .sw_sel(sw_sel), .sw_addr(sw_addr),
        .sw_wdata(sw_wdata), .sw_rvalid(sw_rvalid), .sw_rdata(sw_rdata)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic sw_write(input logic sel, input logic [10:0] addr, input logic [31:0] data);
        @(negedge clk);
        sw_en = 1'b1; sw_wr = 1'b1; sw_sel = sel; sw_addr = addr; sw_wdata = data;
        @(negedge clk);
        sw_en = 1'b0; sw_wr = 1'b0;
    endtask

    task automatic sw_read(input logic sel, input logic [10:0] addr, output logic [31:0] data,
                           output logic vld);
        @(negedge clk);
        sw_en = 1'b1; sw_wr = 1'b0; sw_sel = sel; sw_addr = addr;
        @(negedge clk);
        sw_en = 1'b0;
        data = sw_rdata;
        vld  = sw_rvalid;
    endtask

    task automatic translate(input logic [31:0] va, input logic [2:0] ctx,
                             input logic wr, input logic user, input int stall,
                             output logic [1:0] flt, output logic [27:0] pa,
                             output logic nc, output logic [1:0] sp, output int lat,
                             output logic ready_seen, output logic pulse_ok);
        @(negedge clk);
        ready_seen = req_ready;
        req_valid = 1'b1; req_va = va; req_ctx = ctx; req_write = wr; req_user = user;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        if (stall > 0) begin
            sw_en = 1'b1; sw_wr = 1'b0; sw_sel = 1'b0; sw_addr = 11'h000;
            for (int i = 0; i < stall; i++) begin
                @(negedge clk);
                lat++;
            end
            sw_en = 1'b0;
        end
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        flt = rsp_fault; pa = rsp_pa; nc = rsp_nc; sp = rsp_space;
        @(negedge clk);
        pulse_ok = !rsp_valid && req_ready;
    endtask

    logic [1:0]  f, sp;
    logic [27:0] pa;
    logic        nc, rdy, pls, rv;
    logic [31:0] rd;
    int          lat;

    task automatic t_reset();
        chk("R8", "reset req_ready", {31'd0, req_ready}, 32'd1);
        chk("R8", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R9", "reset sw_rvalid", {31'd0, sw_rvalid}, 32'd0);
    endtask

    task automatic t_load();
        sw_write(1'b0, 11'h105, 32'd3);
        sw_write(1'b0, 11'h205, 32'd4);
        sw_write(1'b1, 11'h0C2, 32'hD400_1234);
        sw_write(1'b1, 11'h102, 32'h8000_0ABC);
        sw_write(1'b1, 11'h0C7, 32'h0000_0055);
        sw_write(1'b1, 11'h0C9, 32'hE000_0777);
        sw_read(1'b0, 11'h105, rd, rv);
        chk("R9", "segment map readback", rd, 32'd3);
        chk("R9", "sw_rvalid on read", {31'd0, rv}, 32'd1);
        sw_read(1'b1, 11'h102, rd, rv);
        chk("R9", "page entry readback", rd, 32'h8000_0ABC);
    endtask

    task automatic t_user_read();
        translate(32'h0014_2345, 3'd1, 1'b0, 1'b1, 0, f, pa, nc, sp, lat, rdy, pls);
        chk("R8", "ready before request", {31'd0, rdy}, 32'd1);
        chk("R8", "latency", lat, 32'd3);
        chk("R8", "single-cycle response", {31'd0, pls}, 32'd1);
        chk("R5", "fault none", {30'd0, f}, 32'd0);
        chk("R5", "physical address", {4'd0, pa}, 32'h0123_4345);
        chk("R5", "non-cacheable", {31'd0, nc}, 32'd1);
        chk("R5", "space type", {30'd0, sp}, 32'd1);
        sw_read(1'b1, 11'h0C2, rd, rv);
        chk("R6", "referenced set on read", rd, 32'hD600_1234);
    endtask

    task automatic t_user_write();
        translate(32'h0014_2345, 3'd1, 1'b1, 1'b1, 0, f, pa, nc, sp, lat, rdy, pls);
        chk("R10", "user write to prot 110", {30'd0, f}, 32'd0);
        sw_read(1'b1, 11'h0C2, rd, rv);
        chk("R6", "modified set on write", rd, 32'hD700_1234);
    endtask

    task automatic t_context();
        translate(32'h0014_2345, 3'd2, 1'b0, 1'b1, 0, f, pa, nc, sp, lat, rdy, pls);
        chk("R2", "other context fault", {30'd0, f}, 32'd0);
        chk("R2", "other context address", {4'd0, pa}, 32'h00AB_C345);
        chk("R10", "user read prot 100 nc", {31'd0, nc}, 32'd0);
        translate(32'h0014_2345, 3'd2, 1'b1, 1'b1, 0, f, pa, nc, sp, lat, rdy, pls);
        chk("R10", "user write to prot 100", {30'd0, f}, 32'd3);
        chk("R7", "fault address zero", {4'd0, pa}, 32'd0);
        sw_read(1'b1, 11'h102, rd, rv);
        chk("R7", "entry unchanged after fault", rd, 32'h8200_0ABC);
    endtask

    task automatic t_hole();
        translate(32'h2014_2345, 3'd1, 1'b1, 1'b0, 0, f, pa, nc, sp, lat, rdy, pls);
        chk("R1", "hole fault", {30'd0, f}, 32'd1);
        chk("R1", "hole nc zero", {31'd0, nc}, 32'd0);
        sw_read(1'b1, 11'h0C2, rd, rv);
        chk("R1", "entry untouched by hole", rd, 32'hD700_1234);
        translate(32'hE014_2345, 3'd1, 1'b0, 1'b0, 0, f, pa, nc, sp, lat, rdy, pls);
        chk("R1", "top region accepted", {30'd0, f}, 32'd0);
        chk("R2", "upper segment bits ignored", {4'd0, pa}, 32'h0123_4345);
    endtask

    task automatic t_invalid_prot();
        translate(32'h0014_7000, 3'd1, 1'b1, 1'b1, 0, f, pa, nc, sp, lat, rdy, pls);
        chk("R3", "invalid beats write protect", {30'd0, f}, 32'd2);
        sw_read(1'b1, 11'h0C7, rd, rv);
        chk("R7", "invalid entry unchanged", rd, 32'h0000_0055);
        translate(32'h0014_9010, 3'd1, 1'b0, 1'b1, 0, f, pa, nc, sp, lat, rdy, pls);
        chk("R4", "user on supervisor page", {30'd0, f}, 32'd3);
        sw_read(1'b1, 11'h0C9, rd, rv);
        chk("R4", "supervisor entry unchanged", rd, 32'hE000_0777);
        translate(32'h0014_9010, 3'd1, 1'b1, 1'b0, 0, f, pa, nc, sp, lat, rdy, pls);
        chk("R4", "supervisor write ok", {30'd0, f}, 32'd0);
        chk("R5", "supervisor address", {4'd0, pa}, 32'h0077_7010);
        sw_read(1'b1, 11'h0C9, rd, rv);
        chk("R6", "ref and mod on supervisor write", rd, 32'hE300_0777);
    endtask

    task automatic t_stall();
        @(negedge clk);
        sw_en = 1'b1; sw_wr = 1'b0; sw_sel = 1'b1; sw_addr = 11'h0C2;
        #1;
        chk("R9", "ready low during sw access", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        sw_en = 1'b0;
        translate(32'h0014_2345, 3'd1, 1'b0, 1'b1, 2, f, pa, nc, sp, lat, rdy, pls);
        chk("R9", "latency with two stall cycles", lat, 32'd5);
        chk("R9", "stalled translation result", {4'd0, pa}, 32'h0123_4345);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_va = '0; req_ctx = '0; req_write = 1'b0;
        req_user = 1'b0; sw_en = 1'b0; sw_wr = 1'b0; sw_sel = 1'b0; sw_addr = '0; sw_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load();
        t_user_read();
        t_user_write();
        t_context();
        t_hole();
        t_invalid_prot();
        t_stall();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule